// File: doc/BRIEF.md
# Charge-Balance Transient Recovery Controller

This block selects the gate drive for the power switch of a buck converter. During steady regulation it passes through the fixed-frequency PWM signal from an external compensator. It also watches a thermometer code from a window of comparators placed around the voltage reference. When that code leaves the centre level, the block takes the switch away from the PWM path and recovers the output with one pulse pair.

The first interval of the pair is set by the direction of the error. It lasts until the deviation stops growing, which marks the valley or peak of the output. The block measures this time in fast-clock cycles. It then scales the count by a programmable ratio, which stands in for the output-capacitor charge-balance calculation, and the result is the length of the opposite-polarity second interval. The block then holds the switch off until the next switching-period start, returns to PWM, and pulses a flag so that the compensator can clear its error history. A timeout ends the first interval if no extremum appears.

Top module: `cb_recovery_ctrl`

## Requirements
- R1: While in PWM mode, `gateOut` equals `pwmIn` in the same cycle and `dynMode` is 0.
- R2: The error level is the number of ones in `errCode`. The centre level is N_CMP/2, which is 3 by default. A level other than the centre, sampled at a clock edge in PWM mode, puts the block in dynamic mode (`dynMode`=1) from the next cycle. This does not wait for `periodStart`.
- R3: If the entry level is below the centre (undershoot), the first interval drives `gateOut`=1. If it is above the centre (overshoot), the first interval drives `gateOut`=0.
- R4: The deviation is the distance of the level from the centre, counted in the entry direction. Call the entry sample d0, and call the sample at the edge ending first-interval cycle k dk. The first interval ends at the first k>=2 where dk<=d(k-1) and d(k-1)<=d(k-2). T1 = k.
- R5: The second interval drives the opposite gate polarity for T2 cycles. T2 = max(1, min(2^CNT_W-1, floor(T1*ratioCfg/2^RATIO_FRAC))), where RATIO_FRAC is 4 by default.
- R6: After the second interval, `gateOut` is 0 and `dynMode` stays 1. The error code is ignored until a clock edge sees `periodStart`=1. PWM mode starts in the next cycle.
- R7: `histClear` is high for exactly the first PWM cycle after a recovery, and at no other time.
- R8: If R4 finds no extremum within `timeoutCfg` first-interval cycles, the second interval is skipped. The block moves straight to the wait of R6.
- R9: During and after reset the block is in PWM mode, with `histClear` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| errCode | input | N_CMP | Thermometer code from the windowed comparators |
| pwmIn | input | 1 | Gate signal from the PWM compensator |
| periodStart | input | 1 | Pulse marking the start of a switching period |
| ratioCfg | input | RATIO_W | Second/first interval ratio, RATIO_FRAC fraction bits |
| timeoutCfg | input | CNT_W | Maximum first-interval length in cycles |
| gateOut | output | 1 | Power switch gate drive |
| dynMode | output | 1 | High while recovery owns the switch |
| histClear | output | 1 | One-cycle pulse on return to PWM |

## Verification
Some properties are checked on every cycle. The assertions cover prompt entry into dynamic mode, the polarity flip between the two intervals, a non-zero second-interval length that counts down by one, and a history-clear pulse that lasts one cycle and appears only in PWM mode. Other behaviour needs the bench's scenarios. Exact interval lengths for different deviation profiles and ratios, the clamp of the second interval to one cycle, the timeout path, and the code being ignored while waiting for the period start can only be seen by counting gate cycles.

// File: rtl/cb_recovery_pkg.sv
package cb_recovery_pkg;

  typedef enum logic [1:0] {
    ST_PWM    = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_SYNC   = 2'd3
  } recState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch entry direction and deviation, start the measure
    logic track;     // one more first-interval sample
    logic loadSec;   // load the scaled second-interval length
    logic countSec;  // count down the second interval
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic outWin;    // level away from the centre
    logic dirLow;    // latched: the entry was an undershoot
    logic extremum;  // valley or peak seen on this sample
    logic timeUp;    // measured time reached the timeout
    logic secLast;   // last cycle of the second interval
  } dpStat_t;

endpackage

// File: rtl/cb_recovery_dp.sv
module cb_recovery_dp
  import cb_recovery_pkg::*;
#(
  parameter int N_CMP      = 6,
  parameter int CNT_W      = 10,
  parameter int RATIO_W    = 8,
  parameter int RATIO_FRAC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CMP-1:0]   errCode,
  input  logic [RATIO_W-1:0] ratioCfg,
  input  logic [CNT_W-1:0]   timeoutCfg,
  input  dpCtrl_t            ctrl,
  output dpStat_t            stat
);
  localparam int LVL_W = $clog2(N_CMP + 1);
  localparam int MID   = N_CMP / 2;
  localparam int PROD_W = CNT_W + RATIO_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic signed [LVL_W:0] MID_S = (LVL_W+1)'(MID);

  logic [LVL_W-1:0] level;
  logic signed [LVL_W:0] levelS, devEntry, devNow, prevDev;
  logic lowSide, dirLow, stallSeen, rising;
  logic [CNT_W-1:0] measCnt, downCnt, secLen;
  logic [PROD_W-1:0] prod, scaled;

  // population count of the comparator code
  always_comb begin
    level = '0;
    for (int i = 0; i < N_CMP; i++)
      level = level + {{(LVL_W-1){1'b0}}, errCode[i]};
  end

  assign levelS   = signed'({1'b0, level});
  assign lowSide  = (int'(level) < MID);
  assign devEntry = lowSide ? (MID_S - levelS) : (levelS - MID_S);
  assign devNow   = dirLow  ? (MID_S - levelS) : (levelS - MID_S);
  assign rising   = (devNow > prevDev);

  // charge-balance scaling of the measured time
  assign prod   = PROD_W'(measCnt) * PROD_W'(ratioCfg);
  assign scaled = prod >> RATIO_FRAC;
  always_comb begin
    if (scaled > PROD_W'(CNT_MAX))  secLen = CNT_MAX;
    else if (scaled == '0)          secLen = CNT_W'(1);
    else                            secLen = scaled[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirLow    <= 1'b0;
      prevDev   <= '0;
      stallSeen <= 1'b0;
      measCnt   <= '0;
      downCnt   <= '0;
    end else begin
      if (ctrl.capture) begin
        dirLow    <= lowSide;
        prevDev   <= devEntry;
        stallSeen <= 1'b0;
        measCnt   <= CNT_W'(1);
      end else if (ctrl.track) begin
        prevDev   <= devNow;
        stallSeen <= !rising;
        if (measCnt != CNT_MAX) measCnt <= measCnt + CNT_W'(1);
      end
      if (ctrl.loadSec)       downCnt <= secLen;
      else if (ctrl.countSec) downCnt <= downCnt - CNT_W'(1);
    end
  end

  assign stat.outWin   = (int'(level) != MID);
  assign stat.dirLow   = dirLow;
  assign stat.extremum = stallSeen && !rising;
  assign stat.timeUp   = (measCnt >= timeoutCfg);
  assign stat.secLast  = (downCnt == CNT_W'(1));

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl.capture, ctrl.track, ctrl.loadSec, ctrl.countSec}));  // R4
  AST_MEAS_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.track |=> (measCnt != '0));  // R4
  AST_SEC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.loadSec |=> (downCnt != '0));  // R5
  AST_SEC_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.countSec && !stat.secLast) |=> (downCnt == $past(downCnt) - CNT_W'(1)));  // R5

endmodule

// File: rtl/cb_recovery_fsm.sv
module cb_recovery_fsm
  import cb_recovery_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pwmIn,
  input  logic    periodStart,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    gateOut,
  output logic    dynMode,
  output logic    histClear
);
  recState_t state, stateNext;

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    unique case (state)
      ST_PWM: if (stat.outWin) begin
        ctrl.capture = 1'b1;
        stateNext    = ST_FIRST;
      end
      ST_FIRST: begin
        if (stat.extremum) begin
          ctrl.loadSec = 1'b1;
          stateNext    = ST_SECOND;
        end else if (stat.timeUp) begin
          stateNext = ST_SYNC;
        end else begin
          ctrl.track = 1'b1;
        end
      end
      ST_SECOND: begin
        ctrl.countSec = 1'b1;
        if (stat.secLast) stateNext = ST_SYNC;
      end
      ST_SYNC: if (periodStart) stateNext = ST_PWM;
      default: stateNext = ST_PWM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_PWM;
      histClear <= 1'b0;
    end else begin
      state     <= stateNext;
      histClear <= (state == ST_SYNC) && periodStart;
    end
  end

  always_comb begin
    unique case (state)
      ST_PWM:    gateOut = pwmIn;
      ST_FIRST:  gateOut = stat.dirLow;
      ST_SECOND: gateOut = !stat.dirLow;
      default:   gateOut = 1'b0;
    endcase
  end

  assign dynMode = (state != ST_PWM);

  AST_ENTRY_PROMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!dynMode && stat.outWin) |=> dynMode);  // R2
  AST_POLARITY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SECOND && $past(state) == ST_FIRST) |-> (gateOut != $past(gateOut)));  // R5
  AST_HIST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    histClear |=> !histClear);  // R7
  AST_HIST_IN_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    histClear |-> !dynMode);  // R7

endmodule

// File: rtl/cb_recovery_ctrl.sv
module cb_recovery_ctrl
  import cb_recovery_pkg::*;
#(
  parameter int N_CMP      = 6,
  parameter int CNT_W      = 10,
  parameter int RATIO_W    = 8,
  parameter int RATIO_FRAC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CMP-1:0]   errCode,
  input  logic               pwmIn,
  input  logic               periodStart,
  input  logic [RATIO_W-1:0] ratioCfg,
  input  logic [CNT_W-1:0]   timeoutCfg,
  output logic               gateOut,
  output logic               dynMode,
  output logic               histClear
);
  dpCtrl_t ctrl;
  dpStat_t stat;

  cb_recovery_dp #(
    .N_CMP(N_CMP), .CNT_W(CNT_W), .RATIO_W(RATIO_W), .RATIO_FRAC(RATIO_FRAC)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .errCode(errCode), .ratioCfg(ratioCfg),
    .timeoutCfg(timeoutCfg), .ctrl(ctrl), .stat(stat)
  );

  cb_recovery_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .pwmIn(pwmIn), .periodStart(periodStart),
    .stat(stat), .ctrl(ctrl), .gateOut(gateOut), .dynMode(dynMode),
    .histClear(histClear)
  );

endmodule

// File: tb/test_cb_recovery_ctrl.sv
module test_cb_recovery_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_CMP = 6;
  localparam int CNT_W = 10;
  localparam int MID = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_CMP-1:0] errCode = 6'b000111;
  logic pwmIn = 1'b0;
  logic periodStart = 1'b0;
  logic [7:0] ratioCfg = 8'h10;
  logic [CNT_W-1:0] timeoutCfg = 10'd40;
  logic gateOut, dynMode, histClear;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  cb_recovery_ctrl i_cb_recovery_ctrl (
    .clk(clk), .rst_n(rst_n), .errCode(errCode), .pwmIn(pwmIn),
    .periodStart(periodStart), .ratioCfg(ratioCfg), .timeoutCfg(timeoutCfg),
    .gateOut(gateOut), .dynMode(dynMode), .histClear(histClear)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {undershoot, oscillate, steps per level, max deviation, ratio}
  localparam logic [15:0] CASES [6] = '{
    {1'b1, 1'b0, 2'd1, 4'd3, 8'h10},
    {1'b0, 1'b0, 2'd1, 4'd2, 8'h20},
    {1'b1, 1'b0, 2'd2, 4'd3, 8'h18},
    {1'b0, 1'b0, 2'd2, 4'd2, 8'h08},
    {1'b1, 1'b0, 2'd1, 4'd1, 8'h00},
    {1'b0, 1'b0, 2'd1, 4'd3, 8'h05}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int devAt(input int i, input int h, input int r, input bit osc);
    int d;
    if (osc) return (i % 2 == 0) ? 1 : 2;
    d = i / h + 1;
    return (d > r) ? r : d;
  endfunction

  function automatic logic [N_CMP-1:0] thermo(input int lvl);
    return N_CMP'((1 << lvl) - 1);
  endfunction

  task automatic runCase(input bit low, input int h, input int r, input int ratio,
                         input int tmo, input bit osc);
    int k = 0;
    int t1, t2;
    bit timedOutCase;
    for (int j = 2; j < 64; j++) begin
      if (k == 0 && devAt(j,h,r,osc) <= devAt(j-1,h,r,osc) &&
          devAt(j-1,h,r,osc) <= devAt(j-2,h,r,osc)) k = j;
    end
    timedOutCase = (k == 0) || (k > tmo);
    t1 = timedOutCase ? tmo : k;
    t2 = (t1 * ratio) >> 4;
    if (t2 < 1) t2 = 1;
    if (t2 > 1023) t2 = 1023;
    ratioCfg = 8'(ratio);
    timeoutCfg = CNT_W'(tmo);

    @(negedge clk);
    check(dynMode == 1'b0, "R1 idle before step", int'(dynMode), 0);
    pwmIn = !low;
    errCode = thermo(low ? MID - devAt(0,h,r,osc) : MID + devAt(0,h,r,osc));
    for (int j = 1; j <= t1; j++) begin
      @(negedge clk);
      check(gateOut == low, "R3 R4 first interval polarity", int'(gateOut), int'(low));
      check(dynMode && !histClear, "R2 dynamic mode held", int'(dynMode), 1);
      errCode = thermo(low ? MID - devAt(j,h,r,osc) : MID + devAt(j,h,r,osc));
    end
    if (!timedOutCase) begin
      for (int j = 1; j <= t2; j++) begin
        @(negedge clk);
        check(gateOut == !low, "R5 second interval", int'(gateOut), int'(!low));
        errCode = thermo(MID);
      end
    end
    @(negedge clk);
    check(gateOut == 1'b0 && dynMode, timedOutCase ? "R8 timeout to wait" : "R6 wait after pair",
          int'(gateOut), 0);
    errCode = thermo(MID + 2);
    @(negedge clk);
    check(gateOut == 1'b0 && dynMode, "R6 code ignored while waiting", int'(dynMode), 1);
    errCode = thermo(MID);
    periodStart = 1'b1;
    @(negedge clk);
    check(!dynMode && gateOut == pwmIn, "R6 back to PWM", int'(dynMode), 0);
    check(histClear == 1'b1, "R7 history clear pulse", int'(histClear), 1);
    periodStart = 1'b0;
    @(negedge clk);
    check(histClear == 1'b0, "R7 pulse one cycle", int'(histClear), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    repeat (2) @(negedge clk);
    pwmIn = 1'b1;
    #1;
    check(gateOut == 1'b1 && !dynMode && !histClear, "R9 reset state", int'(gateOut), 1);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 passthrough with steady code, period starts ignored by the flag
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      pwmIn = n[0];
      periodStart = (n == 2);
      #1;
      check(gateOut == pwmIn && !dynMode, "R1 passthrough", int'(gateOut), int'(pwmIn));
      check(histClear == 1'b0, "R7 no pulse in PWM", int'(histClear), 0);
    end
    periodStart = 1'b0;
    // table of recovery scenarios
    for (int n = 0; n < 6; n++)
      runCase(CASES[n][15], int'(CASES[n][13:12]), int'(CASES[n][11:8]),
              int'(CASES[n][7:0]), 40, CASES[n][14]);
    // R8 oscillating error never shows an extremum
    runCase(1'b1, 1, 3, 16, 8, 1'b1);
    // R8 extremum later than timeout
    runCase(1'b0, 2, 3, 16, 4, 1'b0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule